// File: doc/BRIEF.md
# Multidrop Asynchronous Serial Transmitter

This block turns characters written from a processor-side port into asynchronous serial frames on a single output line. A character waits in a one-entry holding register until the shift register is free. It is then moved across and sent as a start bit, 5 to 8 data bits (least significant first) and one or two stop bits. Each bit lasts 16 pulses of an external baud enable.

When the two-bit format field selects multidrop operation, one extra bit is inserted between the last data bit and the first stop bit. This bit tells listening stations whether the character is an address (1) or a payload byte (0). Its value comes from a configuration input. The whole format is captured together with the character at the moment the write is accepted, so software may change the configuration for the next character while the current one is still queued or on the line.

Top module: `mdtx_top`

## Requirements
- R1: While reset is held and right after it is released, `txd` is 1 and `tx_ready` is 1.
- R2: A write (`wr_valid` high while `tx_ready` is 1) is accepted at that clock edge, and `tx_ready` reads 0 in the following cycle. A write made while `tx_ready` is 0 is ignored: that character is never sent and the queued one is sent unchanged.
- R3: A frame consists of a low start bit, the data bits least significant first, and high stop bits. Every bit lasts exactly 16 `baud_tick` pulses. The line is high between frames.
- R4: `cfg_len` selects the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7, 3 gives 8.
- R5: `cfg_stop2` = 0 gives one stop bit and 1 gives two. With a character already queued, consecutive start bits are separated by exactly 16 times the frame bit count of baud ticks.
- R6: When `cfg_fmt` is 2'b11, one address/data bit carrying `cfg_tag` follows the last data bit. For `cfg_fmt` values 00, 01 and 10 no extra bit is sent.
- R7: `cfg_len`, `cfg_stop2`, `cfg_fmt` and `cfg_tag` are sampled at the edge that accepts the write. Later changes do not affect that character.
- R8: A queued character moves into the shift register as soon as the shifter is idle and the transmitter is enabled. `tx_ready` is 1 in the same cycle in which the start bit first appears on `txd`.
- R9: While `tx_en` is 0, `txd` is 1 and no frame starts, and a queued character stays queued until `tx_en` returns to 1. Dropping `tx_en` during a frame returns `txd` to 1 at once and abandons that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmitter enable |
| baud_tick | input | 1 | One-cycle pulse, 16 per bit time |
| wr_valid | input | 1 | Write strobe for a new character |
| wr_data | input | 8 | Character to send (unused high bits ignored) |
| cfg_len | input | 2 | Data length code, 5 + value bits |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| cfg_fmt | input | 2 | Format field; 2'b11 selects multidrop |
| cfg_tag | input | 1 | Address/data bit value for multidrop frames |
| tx_ready | output | 1 | Holding register empty, a write will be accepted |
| txd | output | 1 | Serial output line |

## Verification
A wrong bit-timer count shows as a data bit sampled from its neighbour at mid-bit, within the first frame. It also shows as a start-to-start spacing that differs from 16 ticks per bit in the very next frame. A format latched at the wrong moment, or a write accepted while full, produces a frame whose length, extra bit or payload disagrees with the arithmetic expectation in the first affected frame. A holding register that fails to empty on transfer leaves `tx_ready` low at the start bit, which shows in the same cycle.

// File: rtl/mdtx_pkg.sv
// Package: shared constants, the latched character record, and the helper
// functions that turn one record into a line-order bit vector.
// Assumes the data length range 5..8 and a stop length of 1 or 2 bits.
package mdtx_pkg;

    localparam int DATA_W     = 8;
    localparam int MIN_LEN    = 5;
    localparam int LEN_CODE_W = 2;
    localparam int FMT_W      = 2;
    localparam int MAX_STOP   = 2;
    localparam int FRAME_W    = 1 + DATA_W + 1 + MAX_STOP;
    localparam int CNT_W      = $clog2(FRAME_W + 1);
    localparam logic [FMT_W-1:0] FMT_MULTIDROP = 2'b11;

    typedef struct packed {
        logic [DATA_W-1:0]     data;
        logic [LEN_CODE_W-1:0] len_code;
        logic                  stop2;
        logic                  multidrop;
        logic                  tag;
    } char_t;

    // Number of bit times in the frame for one latched character.
    function automatic logic [CNT_W-1:0] frame_bits(input char_t c);
        int n;
        n = 1 + MIN_LEN + int'(c.len_code) + (c.multidrop ? 1 : 0) + (c.stop2 ? 2 : 1);
        return CNT_W'(n);
    endfunction

    // Line-order frame, index 0 leaves first; unused upper bits are 1 (stop level).
    function automatic logic [FRAME_W-1:0] build_frame(input char_t c);
        logic [FRAME_W-1:0] f;
        int len;
        len = MIN_LEN + int'(c.len_code);
        f   = '1;
        f[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < len) f[1 + i] = c.data[i];
        end
        for (int j = 1; j < FRAME_W; j++) begin
            if (c.multidrop && (j == 1 + len)) f[j] = c.tag;
        end
        return f;
    endfunction

endpackage

// File: rtl/mdtx_holding.sv
// Holding register: one-entry store for a written character plus the format
// settings sampled with it. Assumes the consumer raises take only when full.
module mdtx_holding
    import mdtx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_valid,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [LEN_CODE_W-1:0] cfg_len,
    input  logic                  cfg_stop2,
    input  logic [FMT_W-1:0]      cfg_fmt,
    input  logic                  cfg_tag,
    input  logic                  take,
    output logic                  full,
    output char_t                 held
);

    logic accept;

    // Accept a write only while empty.
    always_comb accept = wr_valid && !full;

    // Capture character and format on accept; empty on transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            held <= '0;
        end else if (accept) begin
            full           <= 1'b1;
            held.data      <= wr_data;
            held.len_code  <= cfg_len;
            held.stop2     <= cfg_stop2;
            held.multidrop <= (cfg_fmt == FMT_MULTIDROP);
            held.tag       <= cfg_tag;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    // R2
    held_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full && wr_valid |=> $stable(held));

    // R8
    take_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> full);

endmodule

// File: rtl/mdtx_bit_timer.sv
// Bit timer: counts baud enable pulses and flags the last pulse of each bit
// time. Assumes clear is raised when a frame starts or the block is disabled.
module mdtx_bit_timer #(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic baud_tick,
    output logic bit_done
);

    localparam int TW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam logic [TW-1:0] LAST = TW'(TICKS_PER_BIT - 1);

    logic [TW-1:0] cnt;
    logic [TW-1:0] cnt_next;

    // Flag the final pulse of the current bit time.
    always_comb bit_done = run && baud_tick && (cnt == LAST);

    generate
        if ((1 << TW) == TICKS_PER_BIT) begin : g_pow2
            // Power-of-two count wraps naturally.
            always_comb cnt_next = cnt + 1'b1;
        end else begin : g_mod
            // Other counts wrap explicitly at the last value.
            always_comb cnt_next = (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    endgenerate

    // Advance the count on each baud pulse while a frame runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (run && baud_tick) begin
            cnt <= cnt_next;
        end
    end

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick && !clear |=> $stable(cnt));

endmodule

// File: rtl/mdtx_shifter.sv
// Shifter: loads a queued character as a full line-order frame when idle and
// enabled, then steps one bit per completed bit time. Assumes bit_done comes
// from a timer cleared at each load.
module mdtx_shifter
    import mdtx_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   enable,
    input  logic   hold_full,
    input  char_t  held,
    input  logic   bit_done,
    output logic   take,
    output logic   busy,
    output logic   line
);

    logic [FRAME_W-1:0] sr;
    logic [CNT_W-1:0]   left;

    // Start a frame when idle, enabled and a character waits.
    always_comb take = enable && !busy && hold_full;

    // Present the current bit, idle level otherwise.
    always_comb line = busy ? sr[0] : 1'b1;

    // Frame sequencing: load, shift per bit time, stop after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            sr   <= '1;
            left <= '0;
        end else if (!enable) begin
            busy <= 1'b0;
            sr   <= '1;
            left <= '0;
        end else if (take) begin
            busy <= 1'b1;
            sr   <= build_frame(held);
            left <= frame_bits(held);
        end else if (busy && bit_done) begin
            sr   <= {1'b1, sr[FRAME_W-1:1]};
            left <= left - 1'b1;
            if (left == CNT_W'(1)) busy <= 1'b0;
        end
    end

    // R3
    busy_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (left != '0));

    // R9
    off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !busy);

    // R3
    shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && enable && !bit_done |=> busy && $stable(sr));

endmodule

// File: rtl/mdtx_top.sv
// Top: multidrop-capable asynchronous transmitter. Connects the holding
// register, the bit timer and the shifter. Assumes baud_tick is a one-cycle
// pulse and that the configuration inputs are valid whenever wr_valid is high.
module mdtx_top
    import mdtx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_en,
    input  logic       baud_tick,
    input  logic       wr_valid,
    input  logic [7:0] wr_data,
    input  logic [1:0] cfg_len,
    input  logic       cfg_stop2,
    input  logic [1:0] cfg_fmt,
    input  logic       cfg_tag,
    output logic       tx_ready,
    output logic       txd
);

    logic  hold_full;
    char_t held;
    logic  take;
    logic  busy;
    logic  line;
    logic  bit_done;
    logic  timer_clear;

    mdtx_holding u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .cfg_len   (cfg_len),
        .cfg_stop2 (cfg_stop2),
        .cfg_fmt   (cfg_fmt),
        .cfg_tag   (cfg_tag),
        .take      (take),
        .full      (hold_full),
        .held      (held)
    );

    // Restart bit timing on each load and while disabled.
    always_comb timer_clear = take || !tx_en;

    mdtx_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (timer_clear),
        .run       (busy),
        .baud_tick (baud_tick),
        .bit_done  (bit_done)
    );

    mdtx_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (tx_en),
        .hold_full (hold_full),
        .held      (held),
        .bit_done  (bit_done),
        .take      (take),
        .busy      (busy),
        .line      (line)
    );

    // Ready whenever the holding register is empty.
    always_comb tx_ready = !hold_full;

    // Force the idle level at once when disabled.
    always_comb txd = line | ~tx_en;

    // R8
    ready_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> tx_ready);

    // R3
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) && tx_en |-> !txd);

    // R2
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && tx_ready |=> !tx_ready);

    // R1
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

endmodule

// File: tb/mdtx_top_bench.sv
module mdtx_top_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] cfg_len = 2'd0;
    logic       cfg_stop2 = 1'b0;
    logic [1:0] cfg_fmt = 2'd0;
    logic       cfg_tag = 1'b0;
    logic       tx_ready;
    logic       txd;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int tick_total = 0;

    mdtx_top u_mdtx_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .baud_tick (baud_tick),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .cfg_len   (cfg_len),
        .cfg_stop2 (cfg_stop2),
        .cfg_fmt   (cfg_fmt),
        .cfg_tag   (cfg_tag),
        .tx_ready  (tx_ready),
        .txd       (txd)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (baud_tick) tick_total <= tick_total + 1;
    end

    // Baud pulse every third clock, driven away from the active edge.
    always @(negedge clk) baud_tick = (cyc % 3 == 0);

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int nbits(input int len, input bit md, input bit two);
        return 1 + len + (md ? 1 : 0) + (two ? 2 : 1);
    endfunction

    function automatic int exp_bit(input int i, input logic [7:0] d, input int len,
                                   input bit md, input bit tag);
        if (i == 0) return 0;
        if (i <= len) return int'(d[i-1]);
        if (md && i == len + 1) return int'(tag);
        return 1;
    endfunction

    function automatic logic [7:0] sw_data(input int k);
        return 8'((k * 37 + 11) % 256);
    endfunction

    task automatic write_char(input logic [7:0] d, input logic [1:0] lc, input bit two,
                              input logic [1:0] fmt, input bit tag, input bit junk);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        wr_data   = d;
        cfg_len   = lc;
        cfg_stop2 = two;
        cfg_fmt   = fmt;
        cfg_tag   = tag;
        wr_valid  = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
        check_eq("R2", "tx_ready after accepted write", int'(tx_ready), 0);
        // R7: scramble the configuration right after the write
        cfg_len   = ~cfg_len;
        cfg_stop2 = ~cfg_stop2;
        cfg_fmt   = ~cfg_fmt;
        cfg_tag   = ~cfg_tag;
        if (junk) begin
            wr_data  = 8'hA5;
            wr_valid = 1'b1;
            @(negedge clk);
            wr_valid = 1'b0;
        end
    endtask

    task automatic rx_frame(input logic [7:0] d, input int len, input bit md, input bit tag,
                            input bit two, input string req, output int t0);
        int guard = 0;
        @(negedge clk);
        while (txd === 1'b1 && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        check_eq(req, "frame start seen", int'(guard < 20000), 1);
        t0 = tick_total;
        check_eq("R8", "tx_ready when start bit appears", int'(tx_ready), 1);
        for (int i = 0; i < nbits(len, md, two); i++) begin
            while (tick_total - t0 < 8 + 16 * i) @(negedge clk);
            check_eq(req, $sformatf("bit %0d of char %0h", i, d), int'(txd),
                     exp_bit(i, d, len, md, tag));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog (R3): actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int t0;
        int highs;
        repeat (3) @(negedge clk);
        check_eq("R1", "txd in reset", int'(txd), 1);
        check_eq("R1", "tx_ready in reset", int'(tx_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1", "txd after reset", int'(txd), 1);
        check_eq("R1", "tx_ready after reset", int'(tx_ready), 1);

        // R9: queued while disabled
        write_char(8'h3C, 2'd3, 1'b0, 2'b00, 1'b0, 1'b0);
        highs = 0;
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            if (txd === 1'b1) highs++;
        end
        check_eq("R9", "txd high while disabled", highs, 300);
        check_eq("R9", "char still queued while disabled", int'(tx_ready), 0);
        tx_en = 1'b1;
        rx_frame(8'h3C, 8, 1'b0, 1'b0, 1'b0, "R9", t0);
        t0 = tick_total;
        while (tick_total - t0 < 30) @(negedge clk);

        // R4 R5 R6 R7 sweep, back to back
        fork
            begin
                for (int k = 0; k < 32; k++) begin
                    bit md;
                    md = ((k / 8) % 2) == 1;
                    write_char(sw_data(k), 2'(k % 4), ((k / 4) % 2) == 1,
                               md ? 2'b11 : 2'(k % 3), ((k / 16) % 2) == 1, (k % 2) == 1);
                end
            end
            begin
                int prev_t0 = 0;
                int prev_n = 0;
                for (int k = 0; k < 32; k++) begin
                    int len;
                    bit two, md, tag;
                    int ts;
                    len = 5 + k % 4;
                    two = ((k / 4) % 2) == 1;
                    md  = ((k / 8) % 2) == 1;
                    tag = ((k / 16) % 2) == 1;
                    rx_frame(sw_data(k), len, md, tag, two, "R3/R4/R6/R7", ts);
                    if (k > 0) check_eq("R5", $sformatf("start spacing before char %0d", k),
                                        ts - prev_t0, 16 * prev_n);
                    prev_t0 = ts;
                    prev_n  = nbits(len, md, two);
                end
            end
        join
        t0 = tick_total;
        while (tick_total - t0 < 40) @(negedge clk);
        check_eq("R2", "ignored write left nothing queued", int'(tx_ready), 1);

        // R9: abort mid-frame
        write_char(8'h00, 2'd3, 1'b0, 2'b00, 1'b0, 1'b0);
        @(negedge clk);
        while (txd === 1'b1) @(negedge clk);
        t0 = tick_total;
        while (tick_total - t0 < 40) @(negedge clk);
        tx_en = 1'b0;
        #1;
        check_eq("R9", "txd idle at once on disable", int'(txd), 1);
        highs = 0;
        for (int c = 0; c < 100; c++) begin
            @(negedge clk);
            if (txd === 1'b1) highs++;
        end
        check_eq("R9", "txd high after abort", highs, 100);
        check_eq("R9", "tx_ready after abort", int'(tx_ready), 1);
        tx_en = 1'b1;
        highs = 0;
        for (int c = 0; c < 100; c++) begin
            @(negedge clk);
            if (txd === 1'b1) highs++;
        end
        check_eq("R9", "abandoned frame not resumed", highs, 100);
        write_char(8'h96, 2'd2, 1'b1, 2'b11, 1'b1, 1'b0);
        rx_frame(8'h96, 7, 1'b1, 1'b1, 1'b1, "R6", t0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule